// File: doc/BRIEF.md
# Alternating Two-Row Transpose Buffer

This block sits between the two matrix-multiply stages of a separable 8x8 block transform. The first stage sends one intermediate row at a time as a serial stream of wide accumulator results. The buffer scales each result down and saturates it to a 16-bit signed word, then keeps it in one of two row banks. While the second stage drains one bank word by word, the first stage fills the other. The transform's direction does not matter: the forward case (row product first) and the inverse case (column product first) use the same buffer unchanged.

Bank selection runs by itself. After the last word of a row is written, the write side moves to the other bank and the finished bank is offered to the reader. After the last word of a row is read, that bank is free again. If the writer reaches a bank that still holds an unread row, it is held off and a flag reports each refused write.

Top module: `pingpong_row_buf`

## Requirements
- R1: While `rst` is high at a clock edge, both banks become empty and bank 0 is chosen for the next write and the next read. After that edge `row_ready` is 0, `wr_ready` is 1 and `overflow` is 0.
- R2: Each accepted `wr_data` value is read as a signed ACC_W-bit number and shifted right arithmetically by SHIFT bits (rounding toward minus infinity). It is stored as that value, saturated to the range -32768..32767, and appears on `rd_data` in 16-bit two's complement.
- R3: Within a row, words come out on `rd_data` in the order they were written, index 0 first and index 7 last. `rd_data` shows the current word while `row_ready` is 1, and `rd_en` moves on to the next word.
- R4: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. When the eighth accepted write of a row lands while no other row is waiting, `row_ready` is 1 from the next cycle on.
- R5: One bank can be read while the other is being written. Filling the second row during the read of the first corrupts neither row.
- R6: When both banks hold unread rows, `wr_ready` is 0 and `wr_valid` stores nothing. `overflow` is 1 in the cycle after each clock edge where `wr_valid` was 1 and `wr_ready` was 0, and 0 otherwise.
- R7: `rd_en` while `row_ready` is 0 has no effect. The next row written is still read from its word 0.
- R8: The eighth read of a row frees its bank. A writer that was held off sees `wr_ready` return in the next cycle, and the next row goes into the freed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe from the first transform stage |
| wr_data | input | ACC_W (37) | Signed accumulator result to store |
| wr_ready | output | 1 | The current write bank can take a word |
| rd_en | input | 1 | Read strobe from the second transform stage |
| rd_data | output | 16 | Current word of the bank being read |
| row_ready | output | 1 | A complete row is available to read |
| overflow | output | 1 | A write was refused on the previous clock edge |

## Verification
The bench aims at the moment of a bank swap. A design that moves to the other bank one word early or late would mix words of two rows or deliver them rotated, and the per-cycle comparison of `rd_data` shows this at once. A second focus is the blocked writer. A buffer that stores a word while both banks are full would overwrite a row that has not been read. A buffer that frees a bank too late would keep `wr_ready` low for a cycle after the eighth read. Saturation is tested just inside and just outside both limits and with negative odd values, which catch a logical shift or a rounding toward zero. A read strobe on an empty buffer is followed by a fresh row, so any stray pointer movement shows up as a shifted first word.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

    localparam int WORD_W  = 16;
    localparam int ROW_LEN = 8;
    localparam int NBANK   = 2;
    localparam int IDX_W   = $clog2(ROW_LEN);
    localparam int BANK_W  = $clog2(NBANK);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BANK_W-1:0] bank_t;

    localparam idx_t LAST_IDX = idx_t'(ROW_LEN - 1);

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } bank_wr_t;

    function automatic idx_t next_idx(input idx_t i);
        return (i == LAST_IDX) ? '0 : i + idx_t'(1);
    endfunction

endpackage

// File: rtl/rowbuf_clip.sv
module rowbuf_clip
    import rowbuf_pkg::*;
#(
    parameter int ACC_W = 37,
    parameter int SHIFT = 2
) (
    input  logic [ACC_W-1:0] acc,
    output word_t            word
);
    localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'((2 ** (WORD_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO_LIM = ~HI_LIM;

    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        scaled = $signed(acc) >>> SHIFT;
        if (scaled > HI_LIM)
            word = HI_LIM[WORD_W-1:0];
        else if (scaled < LO_LIM)
            word = LO_LIM[WORD_W-1:0];
        else
            word = scaled[WORD_W-1:0];
    end
endmodule

// File: rtl/rowbuf_bank.sv
module rowbuf_bank
    import rowbuf_pkg::*;
(
    input  logic     clk,
    input  bank_wr_t wr,
    input  idx_t     rd_idx,
    output word_t    rd_word
);
    word_t mem [ROW_LEN];

    always_ff @(posedge clk) begin
        if (wr.en)
            mem[wr.idx] <= wr.data;
    end

    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/rowbuf_seq.sv
module rowbuf_seq
    import rowbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_valid,
    input  logic  rd_en,
    output logic  wr_ready,
    output logic  wr_fire,
    output logic  row_ready,
    output logic  overflow,
    output bank_t wr_bank,
    output idx_t  wr_idx,
    output bank_t rd_bank,
    output idx_t  rd_idx
);
    logic [NBANK-1:0] full;
    logic rd_fire, wr_last, rd_last;

    always_comb begin
        wr_ready  = ~full[wr_bank];
        row_ready = full[rd_bank];
        wr_fire   = wr_valid & wr_ready;
        rd_fire   = rd_en & row_ready;
        wr_last   = wr_fire && (wr_idx == LAST_IDX);
        rd_last   = rd_fire && (rd_idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full     <= '0;
            wr_bank  <= '0;
            rd_bank  <= '0;
            wr_idx   <= '0;
            rd_idx   <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= wr_valid & ~wr_ready;
            if (wr_fire)
                wr_idx <= next_idx(wr_idx);
            if (wr_last)
                wr_bank <= wr_bank + bank_t'(1);
            if (rd_fire)
                rd_idx <= next_idx(rd_idx);
            if (rd_last)
                rd_bank <= rd_bank + bank_t'(1);
            for (int b = 0; b < NBANK; b++) begin
                if (wr_last && (wr_bank == bank_t'(b)))
                    full[b] <= 1'b1;
                else if (rd_last && (rd_bank == bank_t'(b)))
                    full[b] <= 1'b0;
            end
        end
    end

    // R1: reset leaves an empty buffer open for writing
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!row_ready && wr_ready && !overflow));

    // R6: a refused write raises the flag and moves no pointer
    a_r6_no_overflow_write: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (overflow && $stable(wr_idx) && $stable(wr_bank)));

    // R4: completing a row with nothing pending makes it readable
    a_r4_row_ready: assert property (@(posedge clk) disable iff (rst)
        (wr_last && !row_ready && !rd_en) |=> row_ready);

    // R7: strobing an empty read side leaves the read pointer alone
    a_r7_idle_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !row_ready) |=> ($stable(rd_idx) && $stable(rd_bank)));

    // R8: the eighth read frees exactly one bank
    a_r8_bank_freed: assert property (@(posedge clk) disable iff (rst)
        (rd_last && !wr_last) |=> ($countones(full) == $past($countones(full)) - 1));

    // R5: the write bank is never the bank being drained while a row waits
    a_r5_disjoint_banks: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && row_ready) |-> (wr_bank != rd_bank));
endmodule

// File: rtl/pingpong_row_buf.sv
module pingpong_row_buf
    import rowbuf_pkg::*;
#(
    parameter int ACC_W = 37,
    parameter int SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ACC_W-1:0]  wr_data,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              row_ready,
    output logic              overflow
);
    word_t  clipped;
    logic   wr_fire;
    bank_t  wr_bank, rd_bank;
    idx_t   wr_idx, rd_idx;
    word_t  bank_word [NBANK];

    rowbuf_clip #(.ACC_W(ACC_W), .SHIFT(SHIFT)) clip_i (
        .acc  (wr_data),
        .word (clipped)
    );

    rowbuf_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .rd_en     (rd_en),
        .wr_ready  (wr_ready),
        .wr_fire   (wr_fire),
        .row_ready (row_ready),
        .overflow  (overflow),
        .wr_bank   (wr_bank),
        .wr_idx    (wr_idx),
        .rd_bank   (rd_bank),
        .rd_idx    (rd_idx)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_wr_t wr_req;
        always_comb begin
            wr_req.en   = wr_fire && (wr_bank == bank_t'(b));
            wr_req.idx  = wr_idx;
            wr_req.data = clipped;
        end
        rowbuf_bank bank_i (
            .clk     (clk),
            .wr      (wr_req),
            .rd_idx  (rd_idx),
            .rd_word (bank_word[b])
        );
    end

    assign rd_data = bank_word[rd_bank];
endmodule

// File: tb/pingpong_row_buf_tb_top.sv
module pingpong_row_buf_tb_top;
    localparam int ACC_W = 37;
    localparam int SHIFT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0;
    logic [ACC_W-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic wr_ready, row_ready, overflow;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int  rdq[$];
    int  cur[$];
    int  rows_full = 0;
    int  rd_cnt = 0;
    bit  m_ovf = 1'b0;
    bit  started = 1'b0;

    always #2 clk = ~clk;

    pingpong_row_buf #(.ACC_W(ACC_W), .SHIFT(SHIFT)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .row_ready (row_ready),
        .overflow  (overflow)
    );

    function automatic int clipw(longint v);
        longint s = v >>> SHIFT;
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return int'(s);
    endfunction

    task automatic check(bit ok, string what, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit r, bit wv, longint wd, bit re, string tag);
        bit rdy;
        @(negedge clk);
        if (started) begin
            check(row_ready === (rows_full > 0), "R4 row_ready", tag, row_ready, rows_full > 0);
            check(wr_ready === (rows_full < 2), "R6 wr_ready", tag, wr_ready, rows_full < 2);
            check(overflow === m_ovf, "R6 overflow", tag, overflow, m_ovf);
            if (rows_full > 0)
                check(int'($signed(rd_data)) == rdq[0], "R3 rd_data", tag,
                      int'($signed(rd_data)), rdq[0]);
        end
        started = 1'b1;
        rst = r; wr_valid = wv; wr_data = wd[ACC_W-1:0]; rd_en = re;
        if (r) begin
            rdq.delete(); cur.delete();
            rows_full = 0; rd_cnt = 0; m_ovf = 1'b0;
        end else begin
            rdy = (rows_full < 2);
            m_ovf = wv && !rdy;
            if (re && rows_full > 0) begin
                void'(rdq.pop_front());
                rd_cnt++;
                if (rd_cnt == 8) begin rd_cnt = 0; rows_full--; end
            end
            if (wv && rdy) begin
                cur.push_back(clipw(wd));
                if (cur.size() == 8) begin
                    foreach (cur[i]) rdq.push_back(cur[i]);
                    cur.delete();
                    rows_full++;
                end
            end
        end
    endtask

    task automatic write_row(longint base, longint stride, bit re, string tag);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, base + i * stride, re, tag);
    endtask

    task automatic idle(int n, bit re, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, re, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(1'b1, 1'b0, 0, 1'b0, "R1 reset");
        step(1'b1, 1'b0, 0, 1'b0, "R1 reset");
        idle(2, 1'b0, "R1 reset");

        // R7: read strobes on an empty buffer
        idle(3, 1'b1, "R7 idle read");
        // R4 / R3: one row, then drain it
        write_row(40, 12, 1'b0, "R4 first row");
        idle(1, 1'b0, "R4 first row");
        idle(9, 1'b1, "R3 drain order");

        // R2: saturation and arithmetic shift
        step(1'b0, 1'b1, 131068, 1'b0, "R2 max edge");
        step(1'b0, 1'b1, 131072, 1'b0, "R2 above max");
        step(1'b0, 1'b1, -131072, 1'b0, "R2 min edge");
        step(1'b0, 1'b1, -131076, 1'b0, "R2 below min");
        step(1'b0, 1'b1, 7, 1'b0, "R2 pos trunc");
        step(1'b0, 1'b1, -7, 1'b0, "R2 neg floor");
        step(1'b0, 1'b1, 64'sd1 <<< 35, 1'b0, "R2 large pos");
        step(1'b0, 1'b1, -(64'sd1 <<< 35), 1'b0, "R2 large neg");
        idle(9, 1'b1, "R2 read back");

        // R6 / R8: fill both banks, push against the full buffer
        write_row(-500, 33, 1'b0, "R6 fill a");
        write_row(900, -71, 1'b0, "R6 fill b");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 12345, 1'b0, "R6 refused");
        idle(2, 1'b0, "R6 flag clears");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 2222 + i, 1'b1, "R8 drain frees");
        write_row(3000, 5, 1'b1, "R8 refill");
        idle(20, 1'b1, "R8 empty out");

        // R5: continuous writing and reading
        for (int r = 0; r < 6; r++) write_row(r * 1000 - 2500, r + 3, 1'b1, "R5 streaming");
        idle(20, 1'b1, "R5 tail");

        // R5: reader slower than writer
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, i * 97 - 3000, (i % 3) == 0, "R5 slow reader");
        idle(40, 1'b1, "R5 slow tail");

        // R1: reset in mid-stream
        write_row(77, 1, 1'b0, "R1 pre reset");
        step(1'b0, 1'b1, 5, 1'b0, "R1 pre reset");
        step(1'b1, 1'b0, 0, 1'b0, "R1 reset again");
        idle(2, 1'b1, "R1 after reset");
        write_row(-9, 2, 1'b0, "R7 fresh row");
        idle(10, 1'b1, "R7 fresh row");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule